// File: doc/BRIEF.md
# Synchronous Offset REQ Engine (Target Side)

This block drives the target side of a synchronous data transfer on an 8-bit parallel SCSI-style bus. Once started, it pulls bytes from a show-ahead FIFO and sends each one with a REQ pulse. The pulses are spaced by a programmable minimum cycle period. The block counts REQs that the initiator has not yet acknowledged. It holds off further REQs while that count sits at the negotiated limit. Each rising ACK edge from the initiator lowers the count.

Transfer parameters are kept per SCSI ID in a small table written through a configuration port. Each entry holds a synchronous/asynchronous flag, a REQ period and a maximum offset. When `start` is accepted, the entry for `partner_id` is copied into the working registers without any further action. The byte total is `blk_len * blk_cnt`. After the last REQ, the engine waits for the outstanding count to drain to zero and then pulses `done`. If the wait exceeds `drain_limit` clocks, it raises `timeout` instead.

States: S_IDLE (waiting for start), S_LOAD (working registers derived), S_READY (issue decision), S_REQ_HI (REQ asserted), S_REQ_LO (REQ released, rest of the period), S_DRAIN (waiting for ACKs), S_FINISH (done pulse). Transitions:
- accept: S_IDLE→S_LOAD on start.
- arm: S_LOAD→S_READY.
- issue: S_READY→S_REQ_HI, when bytes remain, the FIFO is non-empty and the count is below the limit.
- hold: S_READY→S_READY otherwise, while bytes remain.
- last: S_READY→S_DRAIN, when no bytes remain.
- release: S_REQ_HI→S_REQ_LO.
- short: S_REQ_HI→S_READY, when the low half is one clock.
- rearm: S_REQ_LO→S_READY.
- drained: S_DRAIN→S_FINISH.
- expire: S_DRAIN→S_IDLE on timeout.
- close: S_FINISH→S_IDLE.

Top module: `sync_xfer_engine`

## Requirements
- R1: Each of the 2^ID_W table entries stores a mode bit (1 = synchronous), a period and a maximum offset, written when `cfg_we` is high. After reset every entry is asynchronous, period 16, offset 0.
- R2: On start, the entry addressed by `partner_id` is copied into the working registers. A table write made after that has no effect on the running transfer.
- R3: A transfer issues exactly `blk_len*blk_cnt` REQ pulses. The n-th pulse carries the n-th FIFO byte on `scsi_data` while REQ is high. A zero total issues no REQ and still ends with `done`.
- R4: When not throttled, REQ rising edges are max(period,2) clocks apart. REQ stays high for ceil(period/2) clocks.
- R5: `outstanding` never exceeds the effective limit, and REQ is withheld while it is at that limit. The effective limit is min(offset,32) in synchronous mode with a non-zero offset, and 1 otherwise.
- R6: `scsi_ack` passes through a two-flop synchronizer. Each rising edge lowers `outstanding` by one.
- R7: An ACK rising edge that arrives while `outstanding` is 0 sets `proto_err` and leaves the count at 0. `proto_err` holds until the next start.
- R8: While `fifo_empty` is high, no byte is popped and no REQ is issued. The pause raises no error flag.
- R9: `done` is high for exactly one clock, after all bytes are sent and `outstanding` has returned to 0. `busy` then falls.
- R10: If `outstanding` stays non-zero for more than `drain_limit` clocks after the last REQ period, `timeout` is set (held until the next start), `busy` falls and `done` is not pulsed.
- R11: After reset, `scsi_req`, `fifo_pop`, `busy`, `done`, `proto_err`, `timeout` and `outstanding` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the parameter table |
| cfg_id | input | ID_W | Table entry to write |
| cfg_sync | input | 1 | Mode to store: 1 synchronous, 0 asynchronous |
| cfg_period | input | PER_W | REQ cycle period in clocks to store |
| cfg_offset | input | OFS_W | Maximum offset to store |
| start | input | 1 | Begin a data phase (accepted in S_IDLE) |
| partner_id | input | ID_W | ID of the connected initiator |
| blk_len | input | BLEN_W | Bytes per block |
| blk_cnt | input | NBLK_W | Number of blocks |
| drain_limit | input | TO_W | Drain wait limit in clocks |
| fifo_data | input | 8 | Head byte of the source FIFO |
| fifo_empty | input | 1 | Source FIFO empty |
| fifo_pop | output | 1 | Take the head byte |
| scsi_ack | input | 1 | ACK from the initiator (asynchronous) |
| scsi_req | output | 1 | REQ to the initiator |
| scsi_data | output | 8 | Data byte on the bus |
| outstanding | output | OFS_W | REQs not yet acknowledged |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| proto_err | output | 1 | ACK arrived with no REQ outstanding |
| timeout | output | 1 | Drain wait expired |

## Verification
The hardest situation to reach is a REQ stream held exactly at the offset ceiling, including the 32 clamp. Reaching it needs an initiator that withholds ACK while the engine keeps trying to issue. The bench therefore switches its automatic ACK responder off, programs a fast period with a small or oversized offset, and counts REQ edges after the stream has stalled. It then releases the stall one ACK at a time by hand. The drain timeout is reached the same way, and the orphan-ACK error is produced by pulsing ACK while the engine is idle.

// File: rtl/sxe_pkg.sv
`timescale 1ns/1ps
package sxe_pkg;
    localparam int MAX_OFFSET = 32;
    localparam int RST_PERIOD = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_READY,
        S_REQ_HI,
        S_REQ_LO,
        S_DRAIN,
        S_FINISH
    } sxe_state_t;
endpackage

// File: rtl/sxe_param_table.sv
`timescale 1ns/1ps
module sxe_param_table #(
    parameter int ID_W  = 3,
    parameter int PER_W = 8,
    parameter int OFS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_id,
    input  logic             wr_sync,
    input  logic [PER_W-1:0] wr_period,
    input  logic [OFS_W-1:0] wr_offset,
    input  logic [ID_W-1:0]  rd_id,
    output logic             rd_sync,
    output logic [PER_W-1:0] rd_period,
    output logic [OFS_W-1:0] rd_offset
);
    localparam int ENTRIES = 1 << ID_W;

    logic             sync_r   [ENTRIES];
    logic [PER_W-1:0] period_r [ENTRIES];
    logic [OFS_W-1:0] offset_r [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_r[g]   <= 1'b0;
                period_r[g] <= PER_W'(sxe_pkg::RST_PERIOD);
                offset_r[g] <= '0;
            end else if (wr_en && (wr_id == ID_W'(g))) begin
                sync_r[g]   <= wr_sync;
                period_r[g] <= wr_period;
                offset_r[g] <= wr_offset;
            end
        end
    end

    always_comb begin
        rd_sync   = sync_r[rd_id];
        rd_period = period_r[rd_id];
        rd_offset = offset_r[rd_id];
    end
endmodule

// File: rtl/sxe_ack_sync.sv
`timescale 1ns/1ps
module sxe_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], ack_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign ack_rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/sxe_offset_ctr.sv
`timescale 1ns/1ps
module sxe_offset_ctr #(
    parameter int OFS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             issue,
    input  logic             ack_rise,
    output logic [OFS_W-1:0] count,
    output logic             orphan
);
    logic take;

    assign orphan = ack_rise && (count == '0);
    assign take   = ack_rise && (count != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else begin
            unique case ({issue, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sync_xfer_engine.sv
`timescale 1ns/1ps
module sync_xfer_engine
    import sxe_pkg::*;
#(
    parameter int ID_W   = 3,
    parameter int PER_W  = 8,
    parameter int OFS_W  = 6,
    parameter int BLEN_W = 12,
    parameter int NBLK_W = 8,
    parameter int TO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              cfg_sync,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic [OFS_W-1:0]  cfg_offset,
    input  logic              start,
    input  logic [ID_W-1:0]   partner_id,
    input  logic [BLEN_W-1:0] blk_len,
    input  logic [NBLK_W-1:0] blk_cnt,
    input  logic [TO_W-1:0]   drain_limit,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic              scsi_ack,
    output logic              scsi_req,
    output logic [7:0]        scsi_data,
    output logic [OFS_W-1:0]  outstanding,
    output logic              busy,
    output logic              done,
    output logic              proto_err,
    output logic              timeout
);
    localparam int CNT_W = BLEN_W + NBLK_W;
    localparam logic [OFS_W-1:0] OFS_CAP = OFS_W'(MAX_OFFSET);
    localparam logic [PER_W-1:0] PER_MIN = PER_W'(2);

    sxe_state_t state, nxt;

    // table read and working copies
    logic             tbl_sync;
    logic [PER_W-1:0] tbl_period;
    logic [OFS_W-1:0] tbl_offset;
    logic             act_sync;
    logic [PER_W-1:0] act_period;
    logic [OFS_W-1:0] act_offset;
    logic [OFS_W-1:0] lim_q;
    logic [PER_W-1:0] hi_q;
    logic [PER_W-1:0] lo_q;
    logic [PER_W-1:0] pace;
    logic [CNT_W-1:0] bytes_left;
    logic [TO_W-1:0]  drain_cnt;
    logic [PER_W:0]   per_clamped;

    logic accept;
    logic can_issue;
    logic issue;
    logic ack_rise;
    logic orphan;
    logic expire;

    sxe_param_table #(
        .ID_W (ID_W),
        .PER_W(PER_W),
        .OFS_W(OFS_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_id    (cfg_id),
        .wr_sync  (cfg_sync),
        .wr_period(cfg_period),
        .wr_offset(cfg_offset),
        .rd_id    (partner_id),
        .rd_sync  (tbl_sync),
        .rd_period(tbl_period),
        .rd_offset(tbl_offset)
    );

    sxe_ack_sync #(
        .STAGES(2)
    ) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_in  (scsi_ack),
        .ack_rise(ack_rise)
    );

    sxe_offset_ctr #(
        .OFS_W(OFS_W)
    ) u_ofs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .issue   (issue),
        .ack_rise(ack_rise),
        .count   (outstanding),
        .orphan  (orphan)
    );

    assign accept    = (state == S_IDLE) && start;
    assign can_issue = (bytes_left != '0) && !fifo_empty && (outstanding < lim_q);
    assign expire    = (state == S_DRAIN) && (outstanding != '0) && (drain_cnt >= drain_limit);
    assign per_clamped = (act_period < PER_MIN) ? {1'b0, PER_MIN} : {1'b0, act_period};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_LOAD;
            S_LOAD:   nxt = S_READY;
            S_READY: begin
                if (bytes_left == '0) nxt = S_DRAIN;
                else if (can_issue)   nxt = S_REQ_HI;
            end
            S_REQ_HI: begin
                if (pace == PER_W'(1)) nxt = (lo_q == PER_W'(1)) ? S_READY : S_REQ_LO;
            end
            S_REQ_LO: if (pace == PER_W'(1)) nxt = S_READY;
            S_DRAIN: begin
                if (outstanding == '0) nxt = S_FINISH;
                else if (expire)       nxt = S_IDLE;
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue    = (state == S_READY) && can_issue;
        fifo_pop = issue;
        scsi_req = (state == S_REQ_HI);
        busy     = (state != S_IDLE);
        done     = (state == S_FINISH);
    end

    // working registers captured at accept, derived at load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sync   <= 1'b0;
            act_period <= PER_MIN;
            act_offset <= '0;
            lim_q      <= OFS_W'(1);
            hi_q       <= PER_W'(1);
            lo_q       <= PER_W'(1);
        end else if (accept) begin
            act_sync   <= tbl_sync;
            act_period <= tbl_period;
            act_offset <= tbl_offset;
        end else if (state == S_LOAD) begin
            if (!act_sync || act_offset == '0) lim_q <= OFS_W'(1);
            else if (act_offset > OFS_CAP)      lim_q <= OFS_CAP;
            else                                lim_q <= act_offset;
            hi_q <= PER_W'((per_clamped + 1'b1) >> 1);
            lo_q <= PER_W'(per_clamped >> 1);
        end
    end

    // byte count, pacing counter, data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_left <= '0;
            pace       <= '0;
            scsi_data  <= '0;
        end else begin
            if (accept) begin
                bytes_left <= CNT_W'(blk_len) * CNT_W'(blk_cnt);
            end else if (issue) begin
                bytes_left <= bytes_left - 1'b1;
            end

            if (issue) begin
                pace      <= hi_q;
                scsi_data <= fifo_data;
            end else if (state == S_REQ_HI && pace == PER_W'(1)) begin
                pace <= lo_q - 1'b1;
            end else if ((state == S_REQ_HI || state == S_REQ_LO) && pace != '0) begin
                pace <= pace - 1'b1;
            end
        end
    end

    // drain timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                drain_cnt <= '0;
        else if (state != S_DRAIN) drain_cnt <= '0;
        else if (!expire)          drain_cnt <= drain_cnt + 1'b1;
    end

    // sticky flags, cleared on accept, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            if (orphan)      proto_err <= 1'b1;
            else if (accept) proto_err <= 1'b0;
            if (expire)      timeout   <= 1'b1;
            else if (accept) timeout   <= 1'b0;
        end
    end
endmodule

// File: rtl/sxe_checker.sv
`timescale 1ns/1ps
module sxe_checker #(
    parameter int OFS_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scsi_req,
    input logic             fifo_pop,
    input logic             fifo_empty,
    input logic             busy,
    input logic             done,
    input logic             proto_err,
    input logic             ack_rise,
    input logic [OFS_W-1:0] outstanding,
    input logic [OFS_W-1:0] lim_q
);
    // R5
    ofs_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (outstanding <= lim_q) && (outstanding <= OFS_W'(sxe_pkg::MAX_OFFSET)));

    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R3
    pop_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> $rose(scsi_req));

    // R9
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (outstanding == '0) && !scsi_req);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R7
    orphan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && outstanding == '0 && !fifo_pop) |=> (outstanding == '0) && proto_err);

    // R5
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_req |-> busy);
endmodule

bind sync_xfer_engine sxe_checker #(
    .OFS_W(OFS_W)
) u_sxe_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scsi_req   (scsi_req),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .busy       (busy),
    .done       (done),
    .proto_err  (proto_err),
    .ack_rise   (ack_rise),
    .outstanding(outstanding),
    .lim_q      (lim_q)
);

// File: tb/sync_xfer_engine_test.sv
`timescale 1ns/1ps
module sync_xfer_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_id = '0;
    logic        cfg_sync = 1'b0;
    logic [7:0]  cfg_period = '0;
    logic [5:0]  cfg_offset = '0;
    logic        start = 1'b0;
    logic [2:0]  partner_id = '0;
    logic [11:0] blk_len = '0;
    logic [7:0]  blk_cnt = '0;
    logic [15:0] drain_limit = 16'd200;
    logic [7:0]  fifo_data;
    logic        fifo_empty;
    logic        fifo_pop;
    logic        scsi_ack;
    logic        scsi_req;
    logic [7:0]  scsi_data;
    logic [5:0]  outstanding;
    logic        busy, done, proto_err, timeout;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int rises = 0, last_rise = 0, hi_run = 0, last_hi = 0, max_out = 0, done_cnt = 0;
    int pop_empty = 0, pending = 0, ack_ph = 0;
    int gaps [64];
    logic [7:0] dlog [64];
    logic req_prev = 1'b0;
    logic auto_ack = 1'b0, a_ack = 1'b0, m_ack = 1'b0, fifo_hold = 1'b0;
    logic [7:0] pop_idx = '0;
    bit finished = 1'b0;

    assign fifo_data  = 8'hA0 + pop_idx;
    assign fifo_empty = fifo_hold;
    assign scsi_ack   = a_ack | m_ack;

    sync_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_sync(cfg_sync),
        .cfg_period(cfg_period), .cfg_offset(cfg_offset), .start(start), .partner_id(partner_id),
        .blk_len(blk_len), .blk_cnt(blk_cnt), .drain_limit(drain_limit), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .scsi_ack(scsi_ack), .scsi_req(scsi_req),
        .scsi_data(scsi_data), .outstanding(outstanding), .busy(busy), .done(done),
        .proto_err(proto_err), .timeout(timeout)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fifo_pop) pop_idx <= pop_idx + 8'd1;
    end

    // monitor and automatic ACK responder
    always @(negedge clk) begin
        if (scsi_req && !req_prev) begin
            if (rises < 64) begin
                gaps[rises] = cyc - last_rise;
                dlog[rises] = scsi_data;
            end
            last_rise = cyc;
            rises++;
            hi_run = 0;
            if (auto_ack) pending++;
        end
        if (scsi_req) hi_run++;
        if (!scsi_req && req_prev) last_hi = hi_run;
        req_prev = scsi_req;
        if (int'(outstanding) > max_out) max_out = int'(outstanding);
        if (done) done_cnt++;
        if (fifo_pop && fifo_empty) pop_empty++;
        case (ack_ph)
            0: if (pending > 0) begin a_ack = 1'b1; ack_ph = 1; pending--; end
            1: ack_ph = 2;
            2: begin a_ack = 1'b0; ack_ph = 3; end
            default: ack_ph = 0;
        endcase
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        rises = 0; max_out = 0; done_cnt = 0; pop_empty = 0; last_hi = 0;
        pop_idx = '0;
    endtask

    task automatic write_cfg(input int id, input bit s, input int per, input int ofs);
        @(negedge clk);
        cfg_we = 1'b1; cfg_id = 3'(id); cfg_sync = s; cfg_period = 8'(per); cfg_offset = 6'(ofs);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic kick(input int id, input int len, input int nblk);
        @(negedge clk);
        clear_mon();
        partner_id = 3'(id); blk_len = 12'(len); blk_cnt = 8'(nblk); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit && busy; i++) @(negedge clk);
        clocks(2);
    endtask

    task automatic man_ack();
        @(negedge clk); m_ack = 1'b1;
        clocks(2); m_ack = 1'b0;
        clocks(2);
    endtask

    task automatic t_reset();
        chk("R11 req", scsi_req, 0);
        chk("R11 pop", fifo_pop, 0);
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 perr", proto_err, 0);
        chk("R11 tout", timeout, 0);
        chk("R11 outstanding", outstanding, 0);
    endtask

    task automatic t_reset_entry();
        // entry 7 never written: async, period 16
        auto_ack = 1'b1;
        kick(7, 2, 1);
        wait_idle(400);
        chk("R1 reset entry rises", rises, 2);
        chk("R1 reset entry gap 16", gaps[1], 16);
        chk("R1 reset entry async offset", max_out, 1);
    endtask

    task automatic t_basic();
        write_cfg(2, 1'b1, 6, 8);
        auto_ack = 1'b1;
        kick(2, 3, 2);
        wait_idle(2000);
        chk("R3 rise count", rises, 6);
        for (int k = 0; k < 6; k++) chk("R3 data order", dlog[k], 8'hA0 + k);
        for (int k = 1; k < 6; k++) chk("R4 gap period 6", gaps[k], 6);
        chk("R4 high width 3", last_hi, 3);
        chk("R9 single done", done_cnt, 1);
        chk("R6 drained", outstanding, 0);
        chk("R7 no error", proto_err, 0);
        chk("R9 busy low", busy, 0);
    endtask

    task automatic t_autoload();
        write_cfg(3, 1'b1, 9, 8);
        write_cfg(4, 1'b1, 4, 8);
        auto_ack = 1'b1;
        kick(3, 4, 1);
        clocks(5);
        write_cfg(3, 1'b1, 3, 8);
        wait_idle(2000);
        chk("R2 rises id3", rises, 4);
        for (int k = 1; k < 4; k++) chk("R2 id3 gap unchanged by write", gaps[k], 9);
        chk("R4 odd period high width", last_hi, 5);
        kick(4, 5, 1);
        wait_idle(2000);
        for (int k = 1; k < 5; k++) chk("R2 id4 gap", gaps[k], 4);
        chk("R9 done id4", done_cnt, 1);
    endtask

    task automatic t_offset();
        write_cfg(5, 1'b1, 2, 3);
        auto_ack = 1'b0;
        kick(5, 10, 1);
        clocks(60);
        chk("R5 stalled at limit rises", rises, 3);
        chk("R5 outstanding at limit", outstanding, 3);
        chk("R5 still busy", busy, 1);
        man_ack();
        clocks(10);
        chk("R6 one ACK frees one REQ", rises, 4);
        for (int i = 0; i < 9; i++) begin man_ack(); clocks(4); end
        wait_idle(200);
        chk("R5 max outstanding", max_out, 3);
        chk("R9 done after manual acks", done_cnt, 1);
        chk("R5 rises total", rises, 10);
        // clamp of an oversized offset
        write_cfg(5, 1'b1, 2, 40);
        kick(5, 40, 1);
        clocks(150);
        chk("R5 clamp 32 rises", rises, 32);
        chk("R5 clamp 32 outstanding", outstanding, 32);
        for (int i = 0; i < 40; i++) man_ack();
        wait_idle(200);
        chk("R5 clamp done", done_cnt, 1);
        // async mode with large offset behaves as 1
        write_cfg(6, 1'b0, 2, 8);
        auto_ack = 1'b1;
        kick(6, 6, 1);
        wait_idle(2000);
        chk("R5 async max outstanding", max_out, 1);
        chk("R5 async rises", rises, 6);
    endtask

    task automatic t_orphan();
        auto_ack = 1'b0;
        man_ack();
        clocks(4);
        chk("R7 orphan flag", proto_err, 1);
        chk("R7 count held at 0", outstanding, 0);
        kick(2, 5, 0);
        wait_idle(100);
        chk("R7 cleared by start", proto_err, 0);
        chk("R3 zero total no REQ", rises, 0);
        chk("R3 zero total done", done_cnt, 1);
    endtask

    task automatic t_fifo();
        auto_ack = 1'b1;
        fifo_hold = 1'b1;
        kick(2, 2, 1);
        clocks(40);
        chk("R8 no REQ while empty", rises, 0);
        chk("R8 no pop while empty", pop_empty, 0);
        chk("R8 no error flag", proto_err | timeout, 0);
        chk("R8 waits busy", busy, 1);
        fifo_hold = 1'b0;
        wait_idle(400);
        chk("R8 resumes", rises, 2);
        chk("R8 data after pause", dlog[0], 8'hA0);
        chk("R8 done", done_cnt, 1);
    endtask

    task automatic t_timeout();
        write_cfg(5, 1'b1, 2, 3);
        auto_ack = 1'b0;
        drain_limit = 16'd20;
        kick(5, 2, 1);
        clocks(80);
        chk("R10 timeout flag", timeout, 1);
        chk("R10 busy low", busy, 0);
        chk("R10 no done", done_cnt, 0);
        chk("R10 outstanding left", outstanding, 2);
        drain_limit = 16'd200;
        auto_ack = 1'b1;
        kick(2, 1, 1);
        wait_idle(400);
        chk("R10 flag cleared by start", timeout, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        clocks(3);
        t_reset();
        rst_n = 1'b1;
        clocks(3);
        t_reset();
        t_reset_entry();
        t_basic();
        t_autoload();
        t_offset();
        t_orphan();
        t_fifo();
        t_timeout();
        summary();
    end

    initial begin
        #600000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end
endmodule